// File: doc/BRIEF.md
# Synchronized Prescaler Reset Controller

This block owns a small control register that decides how long the reset lines of two timer prescalers stay asserted. One line serves a single timer's prescaler. That prescaler may run from a slow asynchronous clock. The other line serves a prescaler shared by the remaining timers. Software sets a reset bit through the write port. The bit then drives its reset line and reads back on the readback bus until the hardware clears it.

A synchronization mode bit lets software keep both reset lines asserted for as long as it needs. During that time it can load several timers with matching values. Writing the mode bit back to zero drops both lines on the same edge, so every affected timer starts counting together. When the single timer runs from its asynchronous clock, its reset bit stays set until the slow prescaler confirms the reset. That confirmation is a level signal. It passes through a two-flop synchronizer, and its rising edge clears the bit.

Top module: `psr_sync_ctl`

## Requirements
- R1: After reset the readback bus is 0x00 and both reset lines are low.
- R2: The readback bus places the sync-mode bit at bit 7, the single-timer reset bit at bit 1 and the shared reset bit at bit 0. Bits 6 to 2 always read zero, and data written to them is ignored.
- R3: With the sync-mode bit clear and the asynchronous mode input low, a write with bit 1 or bit 0 set raises that reset line on the write edge. The line drops on the next edge. The shared line behaves this way even when the asynchronous mode input is high.
- R4: Writing zero to a reset bit never sets it.
- R5: While the sync-mode bit is set, a reset bit that is set stays set on every edge until a release write.
- R6: A write with bit 7 clear while the sync-mode bit is set is a release. On that edge it clears the sync-mode bit and both reset bits, whatever bits 1 and 0 of that write hold.
- R7: With the asynchronous mode input high and the sync-mode bit clear, the single-timer reset bit stays set until the confirmation input rises. The bit reads zero after the third clock edge that follows the rise, which covers two synchronizer flops and one edge-detect flop.
- R8: A rise of the confirmation input while the sync-mode bit is set does not clear the single-timer reset bit.
- R9: A write that sets a reset bit wins over a hardware clear of that bit on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| asyncMode | input | 1 | Single timer's prescaler runs from its asynchronous clock |
| asyncRstDone | input | 1 | Level from the slow prescaler confirming that it has been reset |
| singleRst | output | 1 | Reset line to the single timer's prescaler |
| sharedRst | output | 1 | Reset line to the shared prescaler |
| rdData | output | 8 | Register readback |

## Verification
A write changes the readback and the reset lines on the write edge itself. The bench therefore samples on the falling edge right after that edge. The hardware clear in R3 is due one edge later, and a release (R6) acts on its own write edge. For R7 the confirmation input is raised on a falling edge. The bench samples it as still set after the first and second rising edges and as clear after the third. Every sample is taken on a falling edge, half a period away from any register update.

// File: rtl/psr_sync_pkg.sv
package psr_sync_pkg;

  localparam int unsigned REG_W      = 8;
  localparam int unsigned SYNC_POS   = 7;
  localparam int unsigned SINGLE_POS = 1;
  localparam int unsigned SHARED_POS = 0;

  // strobes from control to datapath, one set/clear pair per reset bit
  typedef struct packed {
    logic loadSync;
    logic syncVal;
    logic setSingle;
    logic clrSingle;
    logic setShared;
    logic clrShared;
  } psrStrobe_t;

endpackage

// File: rtl/psr_sync_ctrl.sv
module psr_sync_ctrl
  import psr_sync_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             asyncMode,
  input  logic             asyncRstDone,
  input  logic             syncQ,
  input  logic             singleQ,
  input  logic             sharedQ,
  output psrStrobe_t       strobe,
  output logic             doneRise
);

  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  // chain[SYNC_STAGES-1] is the synchronized level, the top bit its delayed copy
  logic [CHAIN_W-1:0] doneChain;
  logic               releaseWr;
  logic               unusedWrBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneChain <= '0;
    else       doneChain <= {doneChain[CHAIN_W-2:0], asyncRstDone};
  end

  assign doneRise     = doneChain[SYNC_STAGES-1] & ~doneChain[SYNC_STAGES];
  assign releaseWr    = wrEn & syncQ & ~wrData[SYNC_POS];
  assign unusedWrBits = ^wrData;

  always_comb begin
    strobe           = '0;
    strobe.loadSync  = wrEn;
    strobe.syncVal   = wrData[SYNC_POS];
    strobe.setSingle = wrEn & wrData[SINGLE_POS] & ~releaseWr;
    strobe.setShared = wrEn & wrData[SHARED_POS] & ~releaseWr;
    strobe.clrShared = releaseWr | (~syncQ & sharedQ);
    strobe.clrSingle = releaseWr | (~syncQ & singleQ & (~asyncMode | doneRise));
  end

endmodule

// File: rtl/psr_sync_dp.sv
module psr_sync_dp
  import psr_sync_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  psrStrobe_t       strobe,
  output logic             syncQ,
  output logic             singleQ,
  output logic             sharedQ,
  output logic [REG_W-1:0] rdData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 1'b0;
      singleQ <= 1'b0;
      sharedQ <= 1'b0;
    end else begin
      if (strobe.loadSync) syncQ <= strobe.syncVal;
      if (strobe.setSingle)      singleQ <= 1'b1;
      else if (strobe.clrSingle) singleQ <= 1'b0;
      if (strobe.setShared)      sharedQ <= 1'b1;
      else if (strobe.clrShared) sharedQ <= 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < int'(REG_W); i++) begin
      if (i == int'(SYNC_POS))        rdData[i] = syncQ;
      else if (i == int'(SINGLE_POS)) rdData[i] = singleQ;
      else if (i == int'(SHARED_POS)) rdData[i] = sharedQ;
      else                            rdData[i] = 1'b0;
    end
  end

endmodule

// File: rtl/psr_sync_ctl.sv
module psr_sync_ctl
  import psr_sync_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             asyncMode,
  input  logic             asyncRstDone,
  output logic             singleRst,
  output logic             sharedRst,
  output logic [REG_W-1:0] rdData
);

  psrStrobe_t strobe;
  logic       syncQ;
  logic       singleQ;
  logic       sharedQ;
  logic       doneRise;

  psr_sync_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .asyncMode(asyncMode), .asyncRstDone(asyncRstDone),
    .syncQ(syncQ), .singleQ(singleQ), .sharedQ(sharedQ),
    .strobe(strobe), .doneRise(doneRise)
  );

  psr_sync_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .syncQ(syncQ), .singleQ(singleQ), .sharedQ(sharedQ), .rdData(rdData)
  );

  assign singleRst = singleQ;
  assign sharedRst = sharedQ;

endmodule

// File: rtl/psr_sync_chk.sv
module psr_sync_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       asyncMode,
  input logic       singleRst,
  input logic       sharedRst,
  input logic [7:0] rdData,
  input logic       doneRise
);

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[6:2] == 5'b0);

  p_line_matches_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[1] == singleRst) && (rdData[0] == sharedRst));

  p_shared_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[0] && !rdData[7]) |=> sharedRst);

  p_shared_one_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sharedRst && !rdData[7] && !(wrEn && wrData[0])) |=> !sharedRst);

  p_hold_shared_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7] && sharedRst && !(wrEn && !wrData[7])) |=> sharedRst);

  p_hold_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7] && singleRst && !(wrEn && !wrData[7])) |=> singleRst);

  p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[7] && rdData[7]) |=> (!sharedRst && !singleRst && !rdData[7]));

  p_async_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (singleRst && asyncMode && !rdData[7] && !doneRise) |=> singleRst);

  p_async_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (singleRst && asyncMode && !rdData[7] && doneRise && !(wrEn && wrData[1]))
      |=> !singleRst);

endmodule

bind psr_sync_ctl psr_sync_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .asyncMode(asyncMode),
  .singleRst(singleRst), .sharedRst(sharedRst), .rdData(rdData), .doneRise(doneRise)
);

// File: tb/psr_sync_ctl_tb_top.sv
module psr_sync_ctl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       asyncMode = 1'b0;
  logic       asyncRstDone = 1'b0;
  logic       singleRst;
  logic       sharedRst;
  logic [7:0] rdData;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  psr_sync_ctl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .asyncMode(asyncMode), .asyncRstDone(asyncRstDone),
    .singleRst(singleRst), .sharedRst(sharedRst), .rdData(rdData)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // readback plus both lines, compared as one vector
  function automatic logic [9:0] obs();
    return {rdData, singleRst, sharedRst};
  endfunction

  function automatic logic [9:0] expOf(input logic [7:0] r);
    return {r, r[1], r[0]};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = 8'h00;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R1 reset state", obs(), 10'h000);
    rstN = 1'b1;
    tick();
    check("R1 after release of reset", obs(), 10'h000);

    // sweep every write value from idle, synchronous prescaler
    for (int d = 0; d < 256; d++) begin
      logic [7:0] v;
      logic [7:0] e;
      v = d[7:0];
      e = {v[7], 5'b0, v[1], v[0]};
      wr(v);
      check("R2 R4 readback after write", obs(), expOf(e));
      if (v[7]) begin
        for (int k = 0; k < 3; k++) begin
          tick();
          check("R5 bits held in sync mode", obs(), expOf(e));
        end
        wr(8'h03);
        check("R6 release clears all, ignores bits 1:0", obs(), 10'h000);
      end else begin
        tick();
        check("R3 one-cycle pulse cleared", obs(), 10'h000);
      end
    end

    // R9: back-to-back set keeps line high across the clear edge
    wr(8'h01);
    wr(8'h01);
    check("R9 set wins over clear", obs(), expOf(8'h01));
    tick();
    check("R9 cleared after last set", obs(), 10'h000);

    // R7: asynchronous single-timer reset with varying wait before confirmation
    asyncMode = 1'b1;
    for (int w = 0; w < 5; w++) begin
      wr(8'h02);
      check("R7 async bit set", obs(), expOf(8'h02));
      for (int k = 0; k < w + 2; k++) begin
        tick();
        check("R7 async bit held before done", obs(), expOf(8'h02));
      end
      asyncRstDone = 1'b1;
      tick();
      check("R7 held 1st edge after done", obs(), expOf(8'h02));
      tick();
      check("R7 held 2nd edge after done", obs(), expOf(8'h02));
      tick();
      check("R7 cleared 3rd edge after done", obs(), 10'h000);
      tick();
      check("R7 stays clear while done high", obs(), 10'h000);
      asyncRstDone = 1'b0;
      repeat (3) tick();
    end

    // R3: shared line still pulses one cycle in async mode
    wr(8'h03);
    check("R3 both set in async mode", obs(), expOf(8'h03));
    tick();
    check("R3 shared cleared, single pending", obs(), expOf(8'h02));
    asyncRstDone = 1'b1;
    repeat (3) tick();
    check("R7 single cleared by done", obs(), 10'h000);
    asyncRstDone = 1'b0;
    repeat (3) tick();

    // R8: confirmation rise during sync mode does not clear
    wr(8'h82);
    asyncRstDone = 1'b1;
    repeat (5) tick();
    check("R8 done ignored in sync mode", obs(), expOf(8'h82));
    asyncRstDone = 1'b0;
    repeat (3) tick();
    wr(8'h00);
    check("R6 release in async mode", obs(), 10'h000);
    tick();
    check("R6 stays released", obs(), 10'h000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule